// File: doc/BRIEF.md
# Sign Bit Reduction Bus Codec

This block carries signed N-bit two's complement words across a data bus in a code of N+1 wires, chosen so that a swing between a small positive and a small negative value flips only a handful of wires. In a two's complement word, the high bits of a small value only repeat its sign. The encoder keeps the lowest of those sign bits, forces every copy above it to zero, and adds a separate polarity flag as the top wire. The decoder reverses this. For a negative code it finds the highest set payload bit and fills every position above it with ones. For a non-negative code it passes the payload through unchanged.

The transmit side takes words with a valid/ready handshake. The encoded word sits in an output register, which holds it on the bus until the far side accepts it. A meter counts how many code wires flip from one accepted transfer to the next, so that the activity of a traffic pattern can be measured. The receive side takes a code word from the bus and returns the two's complement word from a register one cycle later.

Top module: `sbr_bus_codec`

## Requirements
- R1: The code is W+1 bits wide, and its top bit (bit W) is 1 exactly when the input word is negative.
- R2: For a non-negative word, code bits W-1..0 equal the word. Zero encodes as all zeros.
- R3: For a negative word whose shortest two's complement form has m bits, code bits m-1..0 equal the word's bits m-1..0, and code bits W-1..m are zero. Examples: -1 gives 1_00000001 and -3 gives 1_00000101 at W=8.
- R4: The most negative word, -2^(W-1), encodes as the flag with only bit W-1 set (1_10000000 at W=8) and decodes back exactly.
- R5: When the flag is 0, the decoder copies the low W code bits. When the flag is 1, it sets every bit above the highest set payload bit. decode(encode(x)) equals x for every W-bit x, and rx_word shows the result one clock after rx_code is applied.
- R6: tx_ready is high when bus_valid is low or bus_ready is high. A word accepted on a clock edge appears on bus_code with bus_valid high after that edge. While bus_valid is high and bus_ready is low, bus_code and bus_valid hold their values.
- R7: On each transfer (bus_valid and bus_ready both high), toggle_cnt grows by the number of bits that differ between bus_code and the previously transferred code. That previous code counts as all zeros after reset. With no transfer, toggle_cnt does not change. The count wraps at 2^CNT_W.
- R8: Sending +2 and then -3 flips 4 code wires, where the raw 8-bit words flip 8. Over sequences of small values whose sign changes at every step, the code flips fewer wires than the raw words.
- R9: During and right after synchronous reset (rst high), bus_valid, bus_code, toggle_cnt and rx_word are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | A transmit word is offered |
| tx_ready | output | 1 | The transmit word can be taken this cycle |
| tx_word | input | W | Two's complement word to send |
| bus_valid | output | 1 | bus_code holds a word not yet accepted |
| bus_ready | input | 1 | The far side accepts bus_code |
| bus_code | output | W+1 | Registered sign-reduced code word |
| toggle_cnt | output | CNT_W | Running count of code wires flipped between transfers |
| rx_code | input | W+1 | Code word arriving from the bus |
| rx_word | output | W | Registered decoded two's complement word |

## Verification
The bench sends all 256 byte values through the encoder and checks every code word against a model built from the shortest signed width. It then feeds each code back into the decoder. An encoder that kept one extra sign copy, or cleared the kept sign bit, would miss on -1, -3 and -128. A decoder that filled from the wrong position would break the round trip exactly at the most negative value and at -1. The handshake is held against a stalled receiver: a register that reloads during the stall would replace the pending word, and a meter that counts without a transfer would drift. Sign-alternating traffic of small values checks that the flip count stays below what the raw words produce.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int SBR_MAX_CODE_W = 64;

  // Number of set bits in a vector of up to SBR_MAX_CODE_W bits.
  function automatic int unsigned ones_in(input logic [SBR_MAX_CODE_W-1:0] v);
    int unsigned acc;
    acc = 0;
    for (int i = 0; i < SBR_MAX_CODE_W; i++) acc += int'(v[i]);
    return acc;
  endfunction

endpackage

// File: rtl/sbr_encoder.sv
module sbr_encoder #(
  parameter int W = 8
) (
  input  logic [W-1:0] word_i,
  output logic [W:0]   code_o
);
  // run_hi[j] is set when bits W-1..j of the word are all ones
  logic [W-1:0] run_hi;
  logic [W-1:0] payload;

  assign run_hi[W-1] = word_i[W-1];

  genvar j;
  generate
    for (j = W - 2; j >= 0; j--) begin : g_run
      assign run_hi[j] = word_i[j] & run_hi[j+1];
    end
  endgenerate

  // A bit is a redundant sign copy when every bit from the one below it up to
  // the MSB is one; the lowest bit of the leading run survives.
  assign payload[0] = word_i[0];
  generate
    for (j = 1; j < W; j++) begin : g_pay
      assign payload[j] = word_i[j] & ~run_hi[j-1];
    end
  endgenerate

  assign code_o = {word_i[W-1], payload};
endmodule

// File: rtl/sbr_decoder.sv
module sbr_decoder #(
  parameter int W = 8
) (
  input  logic [W:0]   code_i,
  output logic [W-1:0] word_o
);
  // clear_hi[j] is set when payload bits W-1..j are all zero
  logic [W-1:0] clear_hi;
  logic         neg;

  assign neg = code_i[W];
  assign clear_hi[W-1] = ~code_i[W-1];

  genvar j;
  generate
    for (j = W - 2; j >= 0; j--) begin : g_clr
      assign clear_hi[j] = ~code_i[j] & clear_hi[j+1];
    end
  endgenerate

  assign word_o[0] = code_i[0];
  generate
    for (j = 1; j < W; j++) begin : g_fill
      assign word_o[j] = code_i[j] | (neg & clear_hi[j]);
    end
  endgenerate
endmodule

// File: rtl/sbr_toggle_meter.sv
module sbr_toggle_meter
  import sbr_pkg::*;
#(
  parameter int CW    = 9,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [CW-1:0]    code_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int PAD = SBR_MAX_CODE_W - CW;

  logic [CW-1:0]    prev_code;
  logic [CNT_W-1:0] flips;

  always_comb begin
    flips = CNT_W'(ones_in({{PAD{1'b0}}, code_i ^ prev_code}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_code <= '0;
      count_o   <= '0;
    end else if (fire_i) begin
      prev_code <= code_i;
      count_o   <= count_o + flips;
    end
  end
endmodule

// File: rtl/sbr_bus_codec.sv
module sbr_bus_codec #(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_word,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [W:0]       bus_code,
  output logic [CNT_W-1:0] toggle_cnt,
  input  logic [W:0]       rx_code,
  output logic [W-1:0]     rx_word
);
  localparam int CW = W + 1;

  logic [CW-1:0] enc_code;
  logic [W-1:0]  dec_word;
  logic          take;
  logic          fire;

  assign tx_ready = ~bus_valid | bus_ready;
  assign take     = tx_valid & tx_ready;
  assign fire     = bus_valid & bus_ready;

  sbr_encoder #(.W(W)) u_enc (
    .word_i (tx_word),
    .code_o (enc_code)
  );

  sbr_decoder #(.W(W)) u_dec (
    .code_i (rx_code),
    .word_o (dec_word)
  );

  sbr_toggle_meter #(.CW(CW), .CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .code_i  (bus_code),
    .count_o (toggle_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_code  <= '0;
    end else if (take) begin
      bus_valid <= 1'b1;
      bus_code  <= enc_code;
    end else if (fire) begin
      bus_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_word <= '0;
    else     rx_word <= dec_word;
  end
endmodule

// File: rtl/sbr_bus_codec_chk.sv
module sbr_bus_codec_chk #(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [W-1:0]     tx_word,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [W:0]       bus_code,
  input logic [CNT_W-1:0] toggle_cnt
);
  // R6: a stalled word stays put
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_code));

  // R1: the flag follows the sign of the accepted word
  a_r1_flag_sign: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready |=> bus_valid && (bus_code[W] == $past(tx_word[W-1])));

  // R3: a negative code never carries an empty payload
  a_r3_neg_payload: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_code[W] |-> (bus_code[W-1:0] != '0));

  // R3: no two stacked sign copies at the top of a negative code
  a_r3_no_double_top: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_code[W] && bus_code[W-1] |-> !bus_code[W-2]);

  // R2: a non-negative code has a clear payload MSB
  a_r2_pos_msb: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_code[W] |-> !bus_code[W-1]);

  // R7: the meter moves only on a transfer
  a_r7_idle_count: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_ready) |=> $stable(toggle_cnt));

  // R9: reset empties the bus register
  a_r9_reset_empty: assert property (@(posedge clk)
    rst |=> !bus_valid && (toggle_cnt == '0));
endmodule

bind sbr_bus_codec sbr_bus_codec_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_word    (tx_word),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_code   (bus_code),
  .toggle_cnt (toggle_cnt)
);

// File: tb/sbr_bus_codec_test.sv
module sbr_bus_codec_test;
  localparam int W     = 8;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tx_valid = 1'b0;
  logic             tx_ready;
  logic [W-1:0]     tx_word = '0;
  logic             bus_valid;
  logic             bus_ready = 1'b0;
  logic [W:0]       bus_code;
  logic [CNT_W-1:0] toggle_cnt;
  logic [W:0]       rx_code = '0;
  logic [W-1:0]     rx_word;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sbr_bus_codec #(.W(W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_word(tx_word), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_code(bus_code), .toggle_cnt(toggle_cnt), .rx_code(rx_code),
    .rx_word(rx_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model: the shortest signed width m, then the low m bits under the flag
  function automatic logic [W:0] model_code(input int x);
    int m;
    logic [W-1:0] raw;
    logic [W-1:0] keep;
    raw = W'(x);
    if (x >= 0) return {1'b0, raw};
    m = W;
    for (int k = 1; k <= W; k++) begin
      if (x >= -(1 << (k - 1))) begin m = k; break; end
    end
    keep = '0;
    for (int b = 0; b < m; b++) keep[b] = raw[b];
    return {1'b1, keep};
  endfunction

  function automatic int flips(input logic [W:0] a, input logic [W:0] b);
    int c;
    c = 0;
    for (int i = 0; i <= W; i++) c += int'(a[i] ^ b[i]);
    return c;
  endfunction

  // Offer one word with the receiver ready; returns after the transfer
  task automatic send_word(input int x, output logic [W:0] seen);
    @(negedge clk);
    tx_word   = W'(x);
    tx_valid  = 1'b1;
    bus_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    seen = bus_code;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tx_valid = 1'b0;
    bus_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(bus_valid == 1'b0, "R9 bus_valid", bus_valid, 0);
    check(bus_code == '0, "R9 bus_code", bus_code, 0);
    check(toggle_cnt == '0, "R9 toggle_cnt", toggle_cnt, 0);
    check(rx_word == '0, "R9 rx_word", rx_word, 0);
    check(tx_ready == 1'b1, "R6 ready when empty", tx_ready, 1);
  endtask

  task automatic t_all_values();
    logic [W:0] seen;
    logic [W:0] exp;
    for (int x = -(1 << (W - 1)); x < (1 << (W - 1)); x++) begin
      send_word(x, seen);
      exp = model_code(x);
      if (x == -(1 << (W - 1)))
        check(seen == exp && exp == 9'h180, "R4 min encode", seen, exp);
      else if (x < 0)
        check(seen == exp, "R3 R1 neg encode", seen, exp);
      else
        check(seen == exp, "R2 R1 pos encode", seen, exp);
      rx_code = seen;
      @(posedge clk);
      @(negedge clk);
      check(rx_word == W'(x), "R5 round trip", rx_word, W'(x));
    end
  endtask

  task automatic t_named_codes();
    logic [W:0] seen;
    send_word(-1, seen);
    check(seen == 9'h101, "R3 minus one", seen, 9'h101);
    send_word(-3, seen);
    check(seen == 9'h105, "R3 minus three", seen, 9'h105);
    send_word(0, seen);
    check(seen == 9'h000, "R2 zero", seen, 0);
    // decoder alone, flag 0 copies even a wide payload
    @(negedge clk);
    rx_code = 9'h07f;
    @(posedge clk);
    @(negedge clk);
    check(rx_word == 8'h7f, "R5 flag0 copy", rx_word, 8'h7f);
    rx_code = 9'h110;
    @(posedge clk);
    @(negedge clk);
    check(rx_word == 8'hf0, "R5 flag1 fill", rx_word, 8'hf0);
  endtask

  task automatic t_stall();
    logic [CNT_W-1:0] c0;
    @(negedge clk);
    bus_ready = 1'b0;
    tx_word   = 8'd5;
    tx_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    c0 = toggle_cnt;
    tx_word = 8'hfa; // -6 offered while stalled
    check(tx_ready == 1'b0, "R6 not ready when stalled", tx_ready, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(bus_valid && bus_code == 9'h005, "R6 hold", bus_code, 9'h005);
    check(toggle_cnt == c0, "R7 no count without transfer", toggle_cnt, c0);
    bus_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(bus_code == model_code(-6), "R6 next word after release", bus_code, model_code(-6));
    @(posedge clk);
    @(negedge clk);
    check(bus_valid == 1'b0, "R6 drains", bus_valid, 0);
  endtask

  task automatic t_pair();
    logic [W:0] seen;
    logic [CNT_W-1:0] c1;
    send_word(2, seen);
    c1 = toggle_cnt;
    send_word(-3, seen);
    check(int'(toggle_cnt - c1) == 4, "R8 +2 then -3", toggle_cnt - c1, 4);
    check(flips({1'b0, 8'd2}, {1'b0, 8'hfd}) == 8, "R8 raw reference", 0, 8);
  endtask

  task automatic t_random_small();
    logic [W:0] seen;
    logic [W:0] prev_c;
    logic [W-1:0] prev_w;
    logic [CNT_W-1:0] c0;
    int code_sum, raw_sum, x;
    send_word(0, seen);
    prev_c = '0;
    prev_w = '0;
    c0 = toggle_cnt;
    code_sum = 0;
    raw_sum  = 0;
    for (int i = 0; i < 200; i++) begin
      x = int'($urandom_range(1, 7));
      if (i % 2 == 0) x = -x;
      send_word(x, seen);
      code_sum += flips(prev_c, model_code(x));
      raw_sum  += flips({1'b0, prev_w}, {1'b0, W'(x)});
      prev_c = model_code(x);
      prev_w = W'(x);
    end
    check(int'(toggle_cnt - c0) == code_sum, "R7 count matches", toggle_cnt - c0, code_sum);
    check(code_sum < raw_sum, "R8 fewer flips than raw", code_sum, raw_sum);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_named_codes();
    t_stall();
    t_reset();
    t_pair();
    t_random_small();
    t_all_values();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule